// File: doc/BRIEF.md
# I2C Master Byte FIFO Port

This block sits between a host register interface and an I2C byte engine. It buffers up to eight data bytes in both directions. During a write transfer the host pushes bytes into it and the bus side drains them one at a time toward the target. During a read transfer the bus side fills it with bytes received from the target and the host pops them. The block does not time SCL or SDA. A byte moves on the bus only through a request/acknowledge exchange with the engine, and the engine reports a NACK with a flag.

The block keeps two residual counters, both loaded with the transfer length when a command starts. The host-side counter drops by one for each byte the host moves. The bus-side counter drops by one for each byte moved on the wire. Four sticky flags record protocol misuse. A clear pulse resets the flags, the storage and both counters. Accepted host accesses and command loads each give the bus side one chance to move a byte.

Top module: `i2c_byte_fifo_port`

## Requirements
- R1: The FIFO holds up to 8 bytes in first-in first-out order. Its occupancy appears on the 8-bit `fifo_count`.
- R2: A host write (`host_wr`) is rejected and sets `err_invalid` when `xfer_busy` is 0, or when `xfer_read` is 1 (`xfer_read` 1 = read transfer, 0 = write transfer).
- R3: A host read (`host_rd`) is rejected and sets `err_invalid` when `xfer_busy` is 0 or `xfer_read` is 0. An accepted read places the oldest byte on `host_rdata` from the next cycle.
- R4: A host write to a full FIFO, or a host read from an empty FIFO, is dropped. It sets `err_overrun` unless `pacing_en` is 1.
- R5: Each accepted host byte decrements `be_left` by one. If `be_left` is already 0, the byte is still accepted, `be_left` stays 0 and `err_access` is set.
- R6: An accepted host access, or a `load_len` while `xfer_busy` is 1, arms the bus side for exactly one byte. `bus_req` is high only while armed and `xfer_busy` is 1. The arm is spent when a byte moves, and it is lost when `xfer_busy` falls.
- R7: In the read direction `bus_req` requires a FIFO that is not full, and an acknowledged byte on `bus_rdata` is stored. In the write direction `bus_req` requires a FIFO that is not empty, `bus_wdata` shows the oldest byte, and an acknowledge removes it.
- R8: A write-direction byte acknowledged with `bus_nack` high sets `err_nack` and pulses `xfer_abort` in that same cycle.
- R9: Each byte moved on the bus decrements `fe_left` by one. `fe_left` holds at 0.
- R10: A `clr_err` pulse empties the FIFO, zeroes `fe_left` and `be_left`, clears all four error flags and disarms the bus side, all on one edge.
- R11: `load_len` loads `load_count` into both `fe_left` and `be_left`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host pushes `host_wdata` |
| host_wdata | input | 8 | Host byte to send |
| host_rd | input | 1 | Host pops one byte |
| host_rdata | output | 8 | Last byte the host popped |
| xfer_busy | input | 1 | A transfer is active on the bus |
| xfer_read | input | 1 | 1 = read transfer, 0 = write transfer |
| pacing_en | input | 1 | Suppresses overrun errors |
| load_len | input | 1 | Command start: loads both residual counters |
| load_count | input | 16 | Transfer length in bytes |
| clr_err | input | 1 | Clears errors, FIFO and residual counters |
| bus_req | output | 1 | Bus side wants to move one byte |
| bus_wdata | output | 8 | Byte to send in a write transfer |
| bus_ack | input | 1 | Engine has moved the requested byte |
| bus_nack | input | 1 | Target did not acknowledge the sent byte |
| bus_rdata | input | 8 | Byte received in a read transfer |
| xfer_abort | output | 1 | Transfer terminated by a NACK |
| fifo_count | output | 8 | Current number of stored bytes |
| fe_left | output | 16 | Bus-side residual count |
| be_left | output | 16 | Host-side residual count |
| err_invalid | output | 1 | Host access in the wrong state |
| err_overrun | output | 1 | Host push when full or pop when empty |
| err_access | output | 1 | Host byte beyond the transfer length |
| err_nack | output | 1 | NACK received on a sent byte |

## Verification
The assertions assume that `bus_ack` is raised only while `bus_req` is high, and that the host never raises `host_wr` and `host_rd` in the same cycle. They also assume that `load_len` and `clr_err` never coincide with host accesses. The stimulus derives `bus_ack` from the block's own `bus_req`, drives at most one host strobe per cycle, and gives command loads and clears cycles of their own. `xfer_busy` falls only after a NACK or at the end of a test phase, so the arm is never lost during a check that relies on it.

// File: rtl/i2c_byte_fifo_port.sv
module i2c_byte_fifo_port #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [7:0]       host_wdata,
  input  logic             host_rd,
  output logic [7:0]       host_rdata,
  input  logic             xfer_busy,
  input  logic             xfer_read,
  input  logic             pacing_en,
  input  logic             load_len,
  input  logic [CNT_W-1:0] load_count,
  input  logic             clr_err,
  output logic             bus_req,
  output logic [7:0]       bus_wdata,
  input  logic             bus_ack,
  input  logic             bus_nack,
  input  logic [7:0]       bus_rdata,
  output logic             xfer_abort,
  output logic [7:0]       fifo_count,
  output logic [CNT_W-1:0] fe_left,
  output logic [CNT_W-1:0] be_left,
  output logic             err_invalid,
  output logic             err_overrun,
  output logic             err_access,
  output logic             err_nack
);
  localparam int PW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [OW-1:0] count_q;
  logic          armed;

  logic full, empty, wr_dir, rd_dir;
  logic host_push, host_pop, host_ok, bad_cmd, ovr;
  logic bus_move, bus_push, bus_pop, push, pop, kick;
  logic [7:0] push_data;

  assign full   = (count_q == OW'(DEPTH));
  assign empty  = (count_q == '0);
  assign wr_dir = xfer_busy & ~xfer_read;
  assign rd_dir = xfer_busy & xfer_read;

  assign host_push = host_wr & wr_dir & ~full;
  assign host_pop  = host_rd & rd_dir & ~empty;
  assign host_ok   = host_push | host_pop;
  assign bad_cmd   = (host_wr & ~wr_dir) | (host_rd & ~rd_dir);
  assign ovr       = ~pacing_en & ((host_wr & wr_dir & full) | (host_rd & rd_dir & empty));

  assign bus_req   = armed & xfer_busy & (xfer_read ? ~full : ~empty);
  assign bus_move  = bus_req & bus_ack;
  assign bus_push  = bus_move & xfer_read;
  assign bus_pop   = bus_move & ~xfer_read;
  assign push      = host_push | bus_push;
  assign pop       = host_pop | bus_pop;
  assign push_data = xfer_read ? bus_rdata : host_wdata;
  assign kick      = host_ok | (load_len & xfer_busy);

  assign bus_wdata  = mem[rd_ptr];
  assign xfer_abort = bus_pop & bus_nack;
  assign fifo_count = 8'(count_q);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count_q <= '0;
      armed <= 1'b0;
      fe_left <= '0;
      be_left <= '0;
      host_rdata <= '0;
      err_invalid <= 1'b0;
      err_overrun <= 1'b0;
      err_access <= 1'b0;
      err_nack <= 1'b0;
    end else if (clr_err) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count_q <= '0;
      armed <= 1'b0;
      fe_left <= '0;
      be_left <= '0;
      err_invalid <= 1'b0;
      err_overrun <= 1'b0;
      err_access <= 1'b0;
      err_nack <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count_q <= count_q + OW'(push) - OW'(pop);
      if (host_pop) host_rdata <= mem[rd_ptr];
      armed <= kick | (armed & ~bus_move & xfer_busy);
      if (bad_cmd) err_invalid <= 1'b1;
      if (ovr) err_overrun <= 1'b1;
      if (host_ok && be_left == '0) err_access <= 1'b1;
      if (xfer_abort) err_nack <= 1'b1;
      if (load_len) be_left <= load_count;
      else if (host_ok && be_left != '0) be_left <= be_left - 1'b1;
      if (load_len) fe_left <= load_count;
      else if (bus_move && fe_left != '0) fe_left <= fe_left - 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= 8'(DEPTH)); // R1
  AST_REJECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !(xfer_busy && !xfer_read) && !clr_err |=> err_invalid); // R2
  AST_REJECT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !(xfer_busy && xfer_read) && !clr_err |=> err_invalid); // R3
  AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && xfer_busy && !xfer_read && fifo_count == 8'(DEPTH) && !pacing_en && !clr_err
    |=> err_overrun); // R4
  AST_BE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && xfer_busy && !xfer_read && fifo_count < 8'(DEPTH) && be_left != '0 && !load_len && !clr_err
    |=> be_left == $past(be_left) - 1'b1); // R5
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> xfer_busy); // R6
  AST_REQ_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !xfer_read |-> fifo_count != 8'd0); // R7
  AST_NACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && bus_nack && !xfer_read && !clr_err |=> err_nack); // R8
  AST_FE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && fe_left != '0 && !load_len && !clr_err
    |=> fe_left == $past(fe_left) - 1'b1); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> fifo_count == 8'd0 && fe_left == '0 && be_left == '0 &&
                !err_invalid && !err_overrun && !err_access && !err_nack); // R10
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_len && !clr_err |=> fe_left == $past(load_count) && be_left == $past(load_count)); // R11
endmodule

// File: tb/test_i2c_byte_fifo_port.sv
module test_i2c_byte_fifo_port;
  localparam time CYC = 4ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, xfer_busy = 0, xfer_read = 0, pacing_en = 0;
  logic load_len = 0, clr_err = 0, ack_en = 0, bus_nack = 0;
  logic [7:0] host_wdata = 0, bus_rdata = 0;
  logic [15:0] load_count = 0;
  logic bus_req, bus_ack, xfer_abort;
  logic [7:0] host_rdata, bus_wdata, fifo_count;
  logic [15:0] fe_left, be_left;
  logic err_invalid, err_overrun, err_access, err_nack;

  always #(CYC/2) clk = ~clk;
  assign bus_ack = ack_en & bus_req;

  i2c_byte_fifo_port i_i2c_byte_fifo_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .xfer_busy(xfer_busy),
    .xfer_read(xfer_read), .pacing_en(pacing_en), .load_len(load_len),
    .load_count(load_count), .clr_err(clr_err), .bus_req(bus_req),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_nack(bus_nack),
    .bus_rdata(bus_rdata), .xfer_abort(xfer_abort), .fifo_count(fifo_count),
    .fe_left(fe_left), .be_left(be_left), .err_invalid(err_invalid),
    .err_overrun(err_overrun), .err_access(err_access), .err_nack(err_nack));

  int vectors = 0, misses = 0;
  bit started = 0;

  byte unsigned q[$];
  int fe_m, be_m;
  bit inv_m, ovr_m, acc_m, nak_m, want_m;
  byte unsigned rdata_m;

  function automatic bit req_m();
    return want_m && xfer_busy && (xfer_read ? q.size() < 8 : q.size() > 0);
  endfunction

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      q.delete(); fe_m = 0; be_m = 0; rdata_m = 0;
      inv_m = 0; ovr_m = 0; acc_m = 0; nak_m = 0; want_m = 0;
    end else if (clr_err) begin
      q.delete(); fe_m = 0; be_m = 0;
      inv_m = 0; ovr_m = 0; acc_m = 0; nak_m = 0; want_m = 0;
    end else begin
      int n;
      bit mv, hok;
      n = q.size();
      mv = req_m() && ack_en;
      hok = 0;
      if (host_wr) begin
        if (!xfer_busy || xfer_read) inv_m = 1;
        else if (n == 8) begin if (!pacing_en) ovr_m = 1; end
        else begin q.push_back(host_wdata); hok = 1; end
      end
      if (host_rd) begin
        if (!xfer_busy || !xfer_read) inv_m = 1;
        else if (n == 0) begin if (!pacing_en) ovr_m = 1; end
        else begin rdata_m = q.pop_front(); hok = 1; end
      end
      if (mv) begin
        if (!xfer_read) begin
          void'(q.pop_front());
          if (bus_nack) nak_m = 1;
        end else q.push_back(bus_rdata);
        if (fe_m > 0) fe_m--;
      end
      if (hok) begin
        if (be_m == 0) acc_m = 1; else be_m--;
      end
      if (load_len) begin fe_m = load_count; be_m = load_count; end
      want_m = (hok || (load_len && xfer_busy)) ? 1'b1 : (want_m && !mv && xfer_busy);
    end
  end

  always @(negedge clk) if (started) begin
    cmp("R1 count", fifo_count, q.size());
    cmp("R2 R3 invalid", err_invalid, inv_m);
    cmp("R4 overrun", err_overrun, ovr_m);
    cmp("R5 access", err_access, acc_m);
    cmp("R5 R11 be_left", be_left, be_m);
    cmp("R9 R11 fe_left", fe_left, fe_m);
    cmp("R6 R7 bus_req", bus_req, req_m());
    cmp("R8 nack", err_nack, nak_m);
    cmp("R8 abort", xfer_abort, req_m() && ack_en && bus_nack && !xfer_read);
    cmp("R3 rdata", host_rdata, rdata_m);
    if (req_m() && !xfer_read) cmp("R1 R7 wdata", bus_wdata, q[0]);
  end

  task automatic go();
    @(negedge clk);
    #1;
    host_wr = 0; host_rd = 0; load_len = 0; clr_err = 0;
  endtask

  task automatic check_clear();
    cmp("R10 count", fifo_count, 0);
    cmp("R10 fe", fe_left, 0);
    cmp("R10 be", be_left, 0);
    cmp("R10 errs", {err_invalid, err_overrun, err_access, err_nack}, 0);
  endtask

  initial begin
    #(CYC * 5000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) go();
    rst_n = 1;
    go(); host_wr = 1; host_wdata = 8'h11;                // R2 idle write
    go(); host_rd = 1;                                    // R3 idle read
    go(); clr_err = 1;
    go(); check_clear();
    xfer_busy = 1; xfer_read = 0; load_len = 1; load_count = 16'd10;  // R11
    for (int i = 0; i < 8; i++) begin
      go(); host_wr = 1; host_wdata = 8'hA0 + 8'(i);      // R1 fill
    end
    go(); pacing_en = 1; host_wr = 1; host_wdata = 8'hEE; // R4 paced drop
    go(); pacing_en = 0; host_wr = 1; host_wdata = 8'hEF; // R4 overrun
    go(); host_rd = 1;                                    // R3 read in write
    go(); ack_en = 1;                                     // R6 one byte per arm
    repeat (3) go();
    for (int i = 0; i < 3; i++) begin
      go(); host_wr = 1; host_wdata = 8'hC0 + 8'(i);      // R5 be reaches 0
      go();
    end
    go(); bus_nack = 1; host_wr = 1; host_wdata = 8'hD0;  // R8
    go(); go(); bus_nack = 0; xfer_busy = 0;
    go(); clr_err = 1;
    go(); check_clear();
    xfer_busy = 1; xfer_read = 1; load_len = 1; load_count = 16'd3; bus_rdata = 8'h5A;
    go(); go();
    for (int i = 0; i < 5; i++) begin
      go(); bus_rdata = 8'h60 + 8'(i); host_rd = 1;       // R3 R7 R9
      go();
    end
    ack_en = 0;
    for (int i = 0; i < 3; i++) begin go(); pacing_en = 1; host_rd = 1; end
    go(); pacing_en = 0; host_rd = 1;                     // R4 empty pop
    go(); host_wr = 1; host_wdata = 8'h77;                // R2 write in read
    go(); go(); clr_err = 1;
    go(); check_clear();
    xfer_busy = 0;
    repeat (3) go();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule